// File: doc/BRIEF.md
# Pattern-Unlocked Serial Register Access Controller

This block sits on an SRAM-style bus beside a memory chip. It watches the chip enable, output enable and write enable strobes plus a one-bit data input, and it shares the memory's address space without taking any addresses of its own. While it is locked, every bus cycle belongs to the memory, and the memory chip-enable output follows the chip enable input. To reach the clock registers, software first issues one read cycle and then 64 single-bit write cycles. Together these write cycles carry a fixed 64-bit key.

When all 64 key bits match, the block opens for exactly 64 one-bit transfer cycles. During that window the memory is deselected. A read transfer returns a snapshot of the clock register image that is captured when the block opens. A write transfer collects bits into a shadow register and commits all of them to the clock in a single load pulse. After the 64th transfer the block locks again. A power-fail input and a reset pin abort any session without touching the clock registers. The reset pin can be disabled by a bit inside the clock image. The clock counting logic and the analog power monitoring are not part of this block.

Top module: `phantom_access_ctrl`

## Requirements
- R1: After synchronous reset `mem_ce_n` is 1, `dout` is 0 and `rtc_load` is 0.
- R2: While locked, `mem_ce_n` follows `ce_n` two clock edges later.
- R3: A read cycle followed by 64 write cycles opens access when the data bits equal the key. The key is 64'h5CA33AC55CA33AC5, and write k carries bit k of it. This is bytes C5, 3A, A3, 5C repeated twice, each byte least significant bit first.
- R4: If any single key bit is wrong, that attempt fails. The pointer stops, later writes of the attempt are ignored, and access stays closed after the 64th write.
- R5: A read cycle during recognition restarts the attempt from key bit 0. Write cycles issued before any arming read are ignored.
- R6: In a read transfer, the k-th read cycle drives bit k of the clock image on `dout`. Bit k is register k/8, bit k%8. The image is captured when access opens, so later changes to `rtc_image` are not seen.
- R7: During the 64 transfer cycles `mem_ce_n` stays 1 even while `ce_n` is low. After the 64th cycle the block is locked again.
- R8: If all 64 transfer cycles are writes, one single-cycle `rtc_load` pulse follows, with `rtc_wdata` holding the written bits (write k gives bit k). If any transfer cycle is a read, no load occurs.
- R9: While `pwr_fail` is high, `mem_ce_n` is 1. A session in progress ends with no load, and the block is locked when `pwr_fail` clears.
- R10: A low `rst_pin_n` aborts a session with no load when bit 36 of `rtc_image` (register 4, bit 4) is 0. It is ignored when that bit is 1.
- R11: Strobe activity with `ce_n` high is not a cycle and does not disturb recognition or transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Bus chip enable, active low |
| oe_n | input | 1 | Bus output enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| din | input | 1 | Serial data bit in |
| pwr_fail | input | 1 | Digital power-fail indication |
| rst_pin_n | input | 1 | Abort pin, active low |
| rtc_image | input | 64 | Live clock register image, register r at bits 8r+7..8r |
| dout | output | 1 | Serial data bit out during read transfers |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| rtc_load | output | 1 | One-cycle commit strobe |
| rtc_wdata | output | 64 | Value committed with `rtc_load` |

## Verification
The assertions assume that each bus cycle holds `ce_n` low with exactly one of `oe_n` or `we_n` low. They also assume that `din` is stable while a write strobe is low, and that every strobe phase lasts several clocks so the synchronizer sees it. The stimulus tasks hold each strobe phase and each idle gap for four clocks. They never switch directly from a write to a read while `ce_n` stays low. Power-fail and the abort pin are changed only between bus cycles.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int KEY_BITS = 64;
  localparam logic [KEY_BITS-1:0] UNLOCK_KEY = 64'h5CA33AC55CA33AC5;

  typedef struct packed {
    logic fin;    // a bus cycle ended this clock
    logic wr;     // that cycle was a write
    logic bit_v;  // data bit sampled during it
  } cyc_evt_t;
endpackage

// File: rtl/bus_cycle_detect.sv
module bus_cycle_detect
  import unlock_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     we_n,
  input  logic     din,
  output logic     ce_s,
  output cyc_evt_t evt
);
  logic ce1, oe1, we1, d1;
  logic ce2, oe2, we2, d2;
  logic act1, act2;

  always_ff @(posedge clk) begin
    if (rst) begin
      {ce1, oe1, we1, d1} <= 4'b1110;
      {ce2, oe2, we2, d2} <= 4'b1110;
    end else begin
      {ce1, oe1, we1, d1} <= {ce_n, oe_n, we_n, din};
      {ce2, oe2, we2, d2} <= {ce1, oe1, we1, d1};
    end
  end

  // a cycle is active while chip enable and one strobe are low
  assign act1      = !ce1 && (!oe1 || !we1);
  assign act2      = !ce2 && (!oe2 || !we2);
  assign evt.fin   = act2 && !act1;
  assign evt.wr    = !we2;
  assign evt.bit_v = d2;
  assign ce_s      = ce1;
endmodule

// File: rtl/unlock_matcher.sv
module unlock_matcher
  import unlock_pkg::*;
#(
  parameter int                  PAT_LEN = KEY_BITS,
  parameter logic [PAT_LEN-1:0]  PATTERN = UNLOCK_KEY
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  logic     block,
  input  cyc_evt_t evt,
  output logic     hit
);
  localparam int PI = $clog2(PAT_LEN);
  localparam logic [PI-1:0] LAST = PI'(PAT_LEN - 1);

  logic          armed, miss, match, wr_evt, rd_evt;
  logic [PI-1:0] ptr, wcnt;

  assign wr_evt = evt.fin && evt.wr && !block && !clr;
  assign rd_evt = evt.fin && !evt.wr && !block && !clr;
  assign match  = (evt.bit_v == PATTERN[ptr]);
  assign hit    = wr_evt && armed && !miss && match && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed <= 1'b0;
      miss  <= 1'b0;
      ptr   <= '0;
      wcnt  <= '0;
    end else if (rd_evt) begin
      armed <= 1'b1;
      miss  <= 1'b0;
      ptr   <= '0;
      wcnt  <= '0;
    end else if (wr_evt && armed) begin
      if (wcnt == LAST) begin
        armed <= 1'b0;
        miss  <= 1'b0;
        ptr   <= '0;
        wcnt  <= '0;
      end else begin
        wcnt <= wcnt + 1'b1;
        if (!miss && match) ptr <= ptr + 1'b1;
        else                miss <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bit_transfer_engine.sv
module bit_transfer_engine
  import unlock_pkg::*;
#(
  parameter int XFER_LEN = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                abort,
  input  logic                start,
  input  cyc_evt_t            evt,
  input  logic [XFER_LEN-1:0] live_img,
  output logic                busy,
  output logic                dout,
  output logic                load,
  output logic [XFER_LEN-1:0] shadow
);
  localparam int XI = $clog2(XFER_LEN);
  localparam logic [XI-1:0] LAST = XI'(XFER_LEN - 1);

  logic [XI-1:0] xptr;
  logic          all_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      xptr   <= '0;
      all_wr <= 1'b0;
      load   <= 1'b0;
      dout   <= 1'b0;
      shadow <= '0;
    end else begin
      load <= 1'b0;
      dout <= (busy && !abort) ? shadow[xptr] : 1'b0;
      if (abort) begin
        busy <= 1'b0;
        xptr <= '0;
      end else if (start) begin
        busy   <= 1'b1;
        xptr   <= '0;
        all_wr <= 1'b1;
        shadow <= live_img;
      end else if (busy && evt.fin) begin
        if (evt.wr) shadow[xptr] <= evt.bit_v;
        else        all_wr <= 1'b0;
        if (xptr == LAST) begin
          busy <= 1'b0;
          xptr <= '0;
          load <= all_wr && evt.wr;
        end else begin
          xptr <= xptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/phantom_access_ctrl.sv
module phantom_access_ctrl
  import unlock_pkg::*;
#(
  parameter int                   PAT_LEN        = KEY_BITS,
  parameter logic [PAT_LEN-1:0]   PATTERN        = UNLOCK_KEY,
  parameter int                   XFER_LEN       = 64,
  parameter int                   RST_IGNORE_BIT = 36
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_n,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic                din,
  input  logic                pwr_fail,
  input  logic                rst_pin_n,
  input  logic [XFER_LEN-1:0] rtc_image,
  output logic                dout,
  output logic                mem_ce_n,
  output logic                rtc_load,
  output logic [XFER_LEN-1:0] rtc_wdata
);
  cyc_evt_t evt;
  logic     ce_s, pf_s, rp_s, abort, unlock_hit, xfer_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_s     <= 1'b0;
      rp_s     <= 1'b1;
      mem_ce_n <= 1'b1;
    end else begin
      pf_s     <= pwr_fail;
      rp_s     <= rst_pin_n;
      mem_ce_n <= ce_s || pf_s || xfer_busy;
    end
  end

  assign abort = pf_s || (!rp_s && !rtc_image[RST_IGNORE_BIT]);

  bus_cycle_detect u_det (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .din(din), .ce_s(ce_s), .evt(evt)
  );

  unlock_matcher #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_match (
    .clk(clk), .rst(rst), .clr(abort), .block(xfer_busy),
    .evt(evt), .hit(unlock_hit)
  );

  bit_transfer_engine #(.XFER_LEN(XFER_LEN)) u_xfer (
    .clk(clk), .rst(rst), .abort(abort), .start(unlock_hit), .evt(evt),
    .live_img(rtc_image), .busy(xfer_busy), .dout(dout),
    .load(rtc_load), .shadow(rtc_wdata)
  );
endmodule

// File: rtl/access_ctrl_chk.sv
module access_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic hit,
  input logic pf_s,
  input logic mem_ce_n,
  input logic rtc_load
);
  // R7: memory stays deselected while a transfer session is open
  a_r7_memce_blocked: assert property (@(posedge clk) disable iff (rst)
    busy |=> mem_ce_n);
  // R9: power fail deselects memory and ends the session with no load
  a_r9_pf_memce: assert property (@(posedge clk) disable iff (rst)
    pf_s |=> mem_ce_n);
  a_r9_pf_abort: assert property (@(posedge clk) disable iff (rst)
    pf_s |=> (!busy && !rtc_load));
  // R8: commit strobe only closes a session and lasts one clock
  a_r8_load_from_session: assert property (@(posedge clk) disable iff (rst)
    rtc_load |-> $past(busy));
  a_r8_load_single: assert property (@(posedge clk) disable iff (rst)
    rtc_load |=> !rtc_load);
  // R3: unlock completes only while no session is open
  a_r3_hit_when_idle: assert property (@(posedge clk) disable iff (rst)
    hit |-> !busy);
endmodule

bind phantom_access_ctrl access_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .busy(xfer_busy), .hit(unlock_hit),
  .pf_s(pf_s), .mem_ce_n(mem_ce_n), .rtc_load(rtc_load)
);

// File: tb/tb_phantom_access_ctrl.sv
module tb_phantom_access_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEY  = 64'h5CA33AC55CA33AC5;
  localparam logic [63:0] IMG0 = 64'h1122334455667788;  // bit 36 = 0
  localparam logic [63:0] IMG1 = IMG0 | (64'd1 << 36);
  localparam logic [63:0] WVAL = 64'hDEADBEEF0F1E2D3C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic pwr_fail = 1'b0, rst_pin_n = 1'b1;
  logic [63:0] rtc_image = IMG0;
  logic dout, mem_ce_n, rtc_load;
  logic [63:0] rtc_wdata;

  int tests = 0, fails = 0, load_cnt = 0;
  logic [63:0] last_wdata = '0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phantom_access_ctrl dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .din(din),
    .pwr_fail(pwr_fail), .rst_pin_n(rst_pin_n), .rtc_image(rtc_image),
    .dout(dout), .mem_ce_n(mem_ce_n), .rtc_load(rtc_load), .rtc_wdata(rtc_wdata)
  );

  always @(posedge clk) if (rtc_load) begin
    load_cnt <= load_cnt + 1;
    last_wdata <= rtc_wdata;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic b);
    din = b; ce_n = 1'b0; we_n = 1'b0; idle(4);
    we_n = 1'b1; ce_n = 1'b1; idle(4);
  endtask

  task automatic bread(output logic b, output logic m);
    ce_n = 1'b0; oe_n = 1'b0; idle(4);
    b = dout; m = mem_ce_n;
    oe_n = 1'b1; ce_n = 1'b1; idle(4);
  endtask

  task automatic stray();
    din = ~din; we_n = 1'b0; oe_n = 1'b0; idle(4);
    we_n = 1'b1; oe_n = 1'b1; idle(4);
  endtask

  task automatic unlock();
    logic b, m;
    bread(b, m);
    for (int i = 0; i < 64; i++) bwrite(KEY[i]);
  endtask

  // reads n transfer bits starting at index s; also checks deselect (R7)
  task automatic rd_bits(input int s, input int n, inout logic [63:0] got);
    logic b, m;
    for (int i = s; i < s + n; i++) begin
      bread(b, m);
      got[i] = b;
      if (m !== 1'b1) chk("R7 mem_ce_n high in transfer", {63'd0, m}, 64'd1);
    end
  endtask

  task automatic expect_locked(input string req);
    logic b, m;
    bread(b, m);
    chk(req, {63'd0, m}, 64'd0);
  endtask

  initial begin
    logic [63:0] got;
    logic b, m;
    int lc;
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset values
    chk("R1 mem_ce_n", {63'd0, mem_ce_n}, 64'd1);
    chk("R1 dout", {63'd0, dout}, 64'd0);
    chk("R1 rtc_load", {63'd0, rtc_load}, 64'd0);

    // R2 pass-through of chip enable
    ce_n = 1'b0; idle(4);
    chk("R2 follows low", {63'd0, mem_ce_n}, 64'd0);
    ce_n = 1'b1; idle(4);
    chk("R2 follows high", {63'd0, mem_ce_n}, 64'd1);

    // R5 key writes with no arming read are ignored
    for (int i = 0; i < 64; i++) bwrite(KEY[i]);
    expect_locked("R5 unarmed writes ignored");

    // R3 + R6 read transfer with snapshot
    unlock();
    got = '0;
    rd_bits(0, 32, got);
    rtc_image = ~IMG0;
    rd_bits(32, 32, got);
    rtc_image = IMG0;
    chk("R6 read order and snapshot", got, IMG0);
    expect_locked("R7 relocked after 64 cycles");

    // R8 write transfer commits once
    lc = load_cnt;
    unlock();
    for (int i = 0; i < 64; i++) bwrite(WVAL[i]);
    idle(4);
    chk("R8 one load", 64'(load_cnt - lc), 64'd1);
    chk("R8 committed value", last_wdata, WVAL);

    // R8 mixed transfer gives no load
    lc = load_cnt;
    unlock();
    for (int i = 0; i < 63; i++) bwrite(WVAL[i]);
    bread(b, m);
    idle(4);
    chk("R8 mixed no load", 64'(load_cnt - lc), 64'd0);

    // R4 sweep: one wrong key bit at every position
    lc = load_cnt;
    for (int k = 0; k < 64; k++) begin
      bread(b, m);
      for (int i = 0; i < 64; i++) bwrite(KEY[i] ^ (i == k));
      bread(b, m);
      chk($sformatf("R4 mismatch at bit %0d stays locked", k), {63'd0, m}, 64'd0);
    end
    chk("R4 no load from failed attempts", 64'(load_cnt - lc), 64'd0);

    // R5 read mid-recognition restarts attempt
    bread(b, m);
    for (int i = 0; i < 30; i++) bwrite(KEY[i]);
    unlock();
    got = '0;
    rd_bits(0, 64, got);
    chk("R5 restart then unlock", got, IMG0);

    // R11 interleaved cycles with ce_n high
    bread(b, m);
    for (int i = 0; i < 64; i++) begin stray(); bwrite(KEY[i]); end
    got = '0;
    for (int i = 0; i < 64; i++) begin stray(); rd_bits(i, 1, got); end
    chk("R11 interleaved traffic ignored", got, IMG0);

    // R9 power fail
    ce_n = 1'b0; pwr_fail = 1'b1; idle(4);
    chk("R9 mem_ce_n forced high", {63'd0, mem_ce_n}, 64'd1);
    pwr_fail = 1'b0; idle(4);
    chk("R9 released", {63'd0, mem_ce_n}, 64'd0);
    ce_n = 1'b1; idle(4);
    lc = load_cnt;
    unlock();
    for (int i = 0; i < 20; i++) bwrite(WVAL[i]);
    pwr_fail = 1'b1; idle(10); pwr_fail = 1'b0; idle(4);
    for (int i = 20; i < 64; i++) bwrite(WVAL[i]);
    idle(4);
    chk("R9 aborted write no load", 64'(load_cnt - lc), 64'd0);
    expect_locked("R9 locked after power fail");

    // R10 abort pin honoured when enable bit is 0
    lc = load_cnt;
    unlock();
    got = '0;
    rd_bits(0, 10, got);
    rst_pin_n = 1'b0; idle(4); rst_pin_n = 1'b1; idle(4);
    expect_locked("R10 abort pin honoured");
    chk("R10 no load", 64'(load_cnt - lc), 64'd0);

    // R10 abort pin ignored when enable bit is 1
    rtc_image = IMG1;
    unlock();
    got = '0;
    rd_bits(0, 10, got);
    rst_pin_n = 1'b0; idle(4); rst_pin_n = 1'b1; idle(4);
    rd_bits(10, 54, got);
    chk("R10 abort pin ignored", got, IMG1);
    expect_locked("R7 locked after full session");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule